// File: doc/BRIEF.md
# Masked Machine/Supervisor Control Register File

This block holds the privileged control state of one hart: the status word, the interrupt pending, enable and delegation words, the exception delegation word, both trap vectors, the scratch, exception-PC, cause and fault-address registers for the machine and supervisor levels, and the two counter-enable words. Software reaches them through one port. The port has a write enable, a 12-bit write address and write data. It also has a combinational read address and read data, plus an illegal-access flag.

Each register applies its own write mask. The supervisor status, pending and enable addresses hold no storage of their own. They are filtered windows onto the machine registers. The summary dirty bit of the status word is computed on every read and is not stored. Two side ports feed the register file from the pipeline. The hardware interrupt port overwrites selected pending bits in every cycle. The trap-entry port loads the exception PC, cause and fault address of the target level and pushes the interrupt-enable stack inside the status word.

Top module: `csr_file_top`

## Requirements
- R1: After a synchronous active-low reset, every implemented register reads zero, except that the machine trap vector reads the parameter MTVEC_RESET with bits 1:0 cleared.
- R2: A software write to mip (0x344) changes only bit 1 (supervisor software pending) and bit 5 (supervisor timer pending).
- R3: A software write to mie (0x304) changes only the bits in mask 0x12AA: bits 1, 3, 5, 7, 9 and 12.
- R4: A write to mideleg (0x303) keeps only the delegable bits, mask 0x1222. A write to medeleg (0x302) keeps only the bits in EXC_DELEG_MASK, which defaults to 0x3FF.
- R5: Writes to mtvec (0x305) and stvec (0x105) always store bits 1:0 as zero.
- R6: The counter-enable words at 0x320 (user) and 0x321 (supervisor) store only bits 2:0. All higher bits read zero.
- R7: A write to mstatus (0x300) changes only the bits in mask 0x000FF9AA. Bit 31 reads 1 exactly when bits 14:13 equal 3 or bits 16:15 equal 3.
- R8: sstatus (0x100) reads mstatus ANDed with 0x0005E122, and bit 31 carries the same dirty summary. A write to sstatus changes only those masked bits of mstatus.
- R9: sip (0x144) and sie (0x104) read mip and mie ANDed with mideleg. A write to sip or sie changes only bits that are set in mideleg, and also limited by the mip or mie mask.
- R10: The vendor, architecture and implementation ID words (0xF11, 0xF12, 0xF13) read zero. The hart ID word (0xF14) reads the parameter HART_ID.
- R11: csr_illegal is 1 when the read address is not implemented, and then csr_rdata is zero. It is also 1 when a write targets an unimplemented address or one of 0xF11 to 0xF14, and such a write changes nothing.
- R12: A read of the address being written in the same cycle returns the value held before the write.
- R13: Trap entry to machine level (trap_to_s=0) loads mepc, mcause and mbadaddr. It copies mstatus bit [trap_prv] into bit 7, writes trap_prv into bits 12:11 and clears bit 3. Trap entry to supervisor level loads sepc, scause and sbadaddr. It copies mstatus bit [trap_prv] into bit 5, writes trap_prv[0] into bit 8 and clears bit 1. A software write in the same cycle as a trap is dropped.
- R14: For every bit set in hw_irq_mask and in 0x1AAA, mip takes the bit from hw_irq_val at the next edge. This takes precedence over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_we | input | 1 | Software write enable |
| csr_waddr | input | 12 | Software write address |
| csr_wdata | input | XLEN | Software write data |
| csr_raddr | input | 12 | Read address |
| csr_rdata | output | XLEN | Read data for csr_raddr, combinational |
| csr_illegal | output | 1 | Unimplemented read or illegal write |
| hw_irq_mask | input | XLEN | Pending bits driven by hardware in this cycle |
| hw_irq_val | input | XLEN | Values for the driven pending bits |
| trap_valid | input | 1 | Trap entry this cycle |
| trap_to_s | input | 1 | Trap targets the supervisor level |
| trap_prv | input | 2 | Privilege level at trap time |
| trap_cause | input | XLEN | Cause value to record |
| trap_epc | input | XLEN | Exception PC to record |
| trap_badaddr | input | XLEN | Fault address to record |

## Verification
A corrupted bit of stored state does not appear at the ports until that register is read. It then shows up in the same cycle as a wrong csr_rdata value. A corrupted value can also show up one cycle after a trap or an alias write copies it into the status stack or a masked view. A wrong write mask leaves a stray bit set or cleared, and the next read of that register shows it. A wrong dirty summary or wrong alias filtering can be hidden until the status word holds both FS and XS patterns. For that reason the reference model runs every register each cycle while random addresses are read, so that a difference is caught within a few cycles of when it appears.

// File: rtl/csr_file_pkg.sv
// Package: shared address map, write masks, field positions and the
// register selector used by every unit of the control register file.
// Assumes a register width of at least 32 bits; masks are 32-bit constants.
package csr_file_pkg;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_MSTATUS, SEL_SSTATUS, SEL_MIP, SEL_SIP, SEL_MIE, SEL_SIE,
        SEL_MIDELEG, SEL_MEDELEG, SEL_MTVEC, SEL_STVEC,
        SEL_MSCR, SEL_MEPC, SEL_MCAUSE, SEL_MBAD,
        SEL_SSCR, SEL_SEPC, SEL_SCAUSE, SEL_SBAD,
        SEL_UCEN, SEL_SCEN, SEL_VENDOR, SEL_ARCH, SEL_IMPL, SEL_HART
    } csr_sel_e;

    localparam logic [31:0] MSTATUS_WMASK  = 32'h000F_F9AA;
    localparam logic [31:0] SSTATUS_VMASK  = 32'h0005_E122;
    localparam logic [31:0] MIP_SW_MASK    = 32'h0000_0022;
    localparam logic [31:0] IRQ_ALL_MASK   = 32'h0000_12AA;
    localparam logic [31:0] IRQ_DELEG_MASK = 32'h0000_1222;
    localparam logic [31:0] IRQ_HW_MASK    = 32'h0000_1AAA;

    localparam int SIE_BIT  = 1;
    localparam int MIE_BIT  = 3;
    localparam int SPIE_BIT = 5;
    localparam int MPIE_BIT = 7;
    localparam int SPP_BIT  = 8;
    localparam int MPP_LO   = 11;
    localparam int FS_LO    = 13;
    localparam int XS_LO    = 15;
    localparam int CEN_W    = 3;

    // True for every selector that maps to an implemented address.
    function automatic logic sel_hit(csr_sel_e s);
        return s != SEL_NONE;
    endfunction

    // True for selectors that software may write.
    function automatic logic sel_writable(csr_sel_e s);
        return !(s inside {SEL_NONE, SEL_VENDOR, SEL_ARCH, SEL_IMPL, SEL_HART});
    endfunction

    // Selector of the paired register: level 0 machine, 1 supervisor;
    // index 0 scratch, 1 exception PC, 2 cause, 3 fault address.
    function automatic csr_sel_e pair_sel(int lvl, int idx);
        csr_sel_e r;
        case (lvl * 4 + idx)
            0:       r = SEL_MSCR;
            1:       r = SEL_MEPC;
            2:       r = SEL_MCAUSE;
            3:       r = SEL_MBAD;
            4:       r = SEL_SSCR;
            5:       r = SEL_SEPC;
            6:       r = SEL_SCAUSE;
            default: r = SEL_SBAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/csr_addr_dec.sv
// Address decoder: turns a 12-bit control register address into a selector.
// Purely combinational; unknown addresses give SEL_NONE.
module csr_addr_dec
    import csr_file_pkg::*;
(
    input  logic [11:0] addr,
    output csr_sel_e    sel
);

    // Map each implemented address to its selector.
    always_comb begin
        case (addr)
            12'h100: sel = SEL_SSTATUS;
            12'h104: sel = SEL_SIE;
            12'h105: sel = SEL_STVEC;
            12'h140: sel = SEL_SSCR;
            12'h141: sel = SEL_SEPC;
            12'h142: sel = SEL_SCAUSE;
            12'h143: sel = SEL_SBAD;
            12'h144: sel = SEL_SIP;
            12'h300: sel = SEL_MSTATUS;
            12'h302: sel = SEL_MEDELEG;
            12'h303: sel = SEL_MIDELEG;
            12'h304: sel = SEL_MIE;
            12'h305: sel = SEL_MTVEC;
            12'h320: sel = SEL_UCEN;
            12'h321: sel = SEL_SCEN;
            12'h340: sel = SEL_MSCR;
            12'h341: sel = SEL_MEPC;
            12'h342: sel = SEL_MCAUSE;
            12'h343: sel = SEL_MBAD;
            12'h344: sel = SEL_MIP;
            12'hF11: sel = SEL_VENDOR;
            12'hF12: sel = SEL_ARCH;
            12'hF13: sel = SEL_IMPL;
            12'hF14: sel = SEL_HART;
            default: sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/csr_status_unit.sv
// Status unit: holds the status word, applies the machine and supervisor
// write masks, pushes the enable stack on trap entry and derives the
// summary dirty bit on read. Assumes the caller already blocks writes
// during a trap; trap entry still has priority here.
module csr_status_unit
    import csr_file_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_m,
    input  logic            wr_s,
    input  logic [XLEN-1:0] wdata,
    input  logic            trap_valid,
    input  logic            trap_to_s,
    input  logic [1:0]      trap_prv,
    output logic [XLEN-1:0] mstatus_o,
    output logic [XLEN-1:0] sstatus_o
);

    localparam logic [XLEN-1:0] MW    = XLEN'(MSTATUS_WMASK);
    localparam logic [XLEN-1:0] SV    = XLEN'(SSTATUS_VMASK);
    localparam logic [XLEN-1:0] SDBIT = {1'b1, {(XLEN-1){1'b0}}};

    logic [XLEN-1:0] st_q, st_d;
    logic            pie;
    logic            dirty;

    // Next status: trap stack push first, then masked software writes.
    always_comb begin
        st_d = st_q;
        pie  = st_q[trap_prv];
        if (trap_valid) begin
            if (trap_to_s) begin
                st_d[SPIE_BIT] = pie;
                st_d[SPP_BIT]  = trap_prv[0];
                st_d[SIE_BIT]  = 1'b0;
            end else begin
                st_d[MPIE_BIT]         = pie;
                st_d[MPP_LO +: 2]      = trap_prv;
                st_d[MIE_BIT]          = 1'b0;
            end
        end else if (wr_m) begin
            st_d = (st_q & ~MW) | (wdata & MW);
        end else if (wr_s) begin
            st_d = (st_q & ~SV) | (wdata & SV);
        end
    end

    // Status register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Dirty summary and the two read views.
    always_comb begin
        dirty     = (&st_q[FS_LO +: 2]) | (&st_q[XS_LO +: 2]);
        mstatus_o = (st_q & ~SDBIT) | (dirty ? SDBIT : '0);
        sstatus_o = (st_q & SV) | (dirty ? SDBIT : '0);
    end

    // R13
    trap_m_clears_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_to_s) |=> !mstatus_o[MIE_BIT]);

    // R8
    sview_write_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s && !wr_m && !trap_valid) |=> $stable(mstatus_o & ~SV & ~SDBIT));

endmodule

// File: rtl/csr_irq_unit.sv
// Interrupt unit: pending, enable and delegation words with their masks,
// the delegated supervisor windows and the hardware pending overlay.
// Assumes write strobes are already blocked during trap entry.
module csr_irq_unit
    import csr_file_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_mip,
    input  logic            wr_sip,
    input  logic            wr_mie,
    input  logic            wr_sie,
    input  logic            wr_mideleg,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] hw_mask,
    input  logic [XLEN-1:0] hw_val,
    output logic [XLEN-1:0] mip_o,
    output logic [XLEN-1:0] mie_o,
    output logic [XLEN-1:0] mideleg_o
);

    localparam logic [XLEN-1:0] IP_SW = XLEN'(MIP_SW_MASK);
    localparam logic [XLEN-1:0] IE_W  = XLEN'(IRQ_ALL_MASK);
    localparam logic [XLEN-1:0] DG_W  = XLEN'(IRQ_DELEG_MASK);
    localparam logic [XLEN-1:0] HW_W  = XLEN'(IRQ_HW_MASK);

    logic [XLEN-1:0] ip_q, ie_q, dg_q;
    logic [XLEN-1:0] ip_d, ie_d, dg_d;
    logic [XLEN-1:0] ip_wm, ie_wm, hw_m;

    // Effective masks for this cycle and next-state values.
    always_comb begin
        ip_wm = wr_mip ? IP_SW : (wr_sip ? (IP_SW & dg_q) : '0);
        ie_wm = wr_mie ? IE_W  : (wr_sie ? (IE_W & dg_q)  : '0);
        hw_m  = hw_mask & HW_W;
        ip_d  = (ip_q & ~ip_wm) | (wdata & ip_wm);
        ip_d  = (ip_d & ~hw_m)  | (hw_val & hw_m);
        ie_d  = (ie_q & ~ie_wm) | (wdata & ie_wm);
        dg_d  = wr_mideleg ? (wdata & DG_W) : dg_q;
    end

    // Interrupt registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q <= '0;
            ie_q <= '0;
            dg_q <= '0;
        end else begin
            ip_q <= ip_d;
            ie_q <= ie_d;
            dg_q <= dg_d;
        end
    end

    assign mip_o     = ip_q;
    assign mie_o     = ie_q;
    assign mideleg_o = dg_q;

    // R2
    mip_sw_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mip && (hw_mask & HW_W) == '0) |=> $stable(mip_o & ~IP_SW));

    // R9
    sie_deleg_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sie |=> ((mie_o ^ $past(mie_o)) & ~mideleg_o) == '0);

endmodule

// File: rtl/csr_file_top.sv
// Control register file top: decodes the software port, gates writes
// against trap entry, holds vectors, delegation, counter enables and the
// paired machine/supervisor trap registers, and muxes the read data.
// Assumes one software access per cycle; reads are combinational.
module csr_file_top
    import csr_file_pkg::*;
#(
    parameter int              XLEN           = 32,
    parameter int unsigned     HART_ID        = 0,
    parameter logic [XLEN-1:0] MTVEC_RESET    = XLEN'(32'h100),
    parameter logic [XLEN-1:0] EXC_DELEG_MASK = XLEN'(32'h3FF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [11:0]     csr_waddr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [11:0]     csr_raddr,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    input  logic [XLEN-1:0] hw_irq_mask,
    input  logic [XLEN-1:0] hw_irq_val,
    input  logic            trap_valid,
    input  logic            trap_to_s,
    input  logic [1:0]      trap_prv,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_epc,
    input  logic [XLEN-1:0] trap_badaddr
);

    localparam int NLVL  = 2;
    localparam int NPAIR = 4;

    csr_sel_e        wsel, rsel;
    logic            sw_we;
    logic [XLEN-1:0] mstatus_v, sstatus_v, mip_v, mie_v, mideleg_v;
    logic [XLEN-1:0] medeleg_q, mtvec_q, stvec_q;
    logic [CEN_W-1:0] ucen_q, scen_q;
    logic [XLEN-1:0] pair_rd [NLVL*NPAIR];

    csr_addr_dec u_wdec (.addr(csr_waddr), .sel(wsel));
    csr_addr_dec u_rdec (.addr(csr_raddr), .sel(rsel));

    // Software write is accepted only for writable addresses outside a trap.
    assign sw_we = csr_we && sel_writable(wsel) && !trap_valid;

    csr_status_unit #(.XLEN(XLEN)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_m       (sw_we && wsel == SEL_MSTATUS),
        .wr_s       (sw_we && wsel == SEL_SSTATUS),
        .wdata      (csr_wdata),
        .trap_valid (trap_valid),
        .trap_to_s  (trap_to_s),
        .trap_prv   (trap_prv),
        .mstatus_o  (mstatus_v),
        .sstatus_o  (sstatus_v)
    );

    csr_irq_unit #(.XLEN(XLEN)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_mip     (sw_we && wsel == SEL_MIP),
        .wr_sip     (sw_we && wsel == SEL_SIP),
        .wr_mie     (sw_we && wsel == SEL_MIE),
        .wr_sie     (sw_we && wsel == SEL_SIE),
        .wr_mideleg (sw_we && wsel == SEL_MIDELEG),
        .wdata      (csr_wdata),
        .hw_mask    (hw_irq_mask),
        .hw_val     (hw_irq_val),
        .mip_o      (mip_v),
        .mie_o      (mie_v),
        .mideleg_o  (mideleg_v)
    );

    // Vectors, exception delegation and counter enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            medeleg_q <= '0;
            mtvec_q   <= {MTVEC_RESET[XLEN-1:2], 2'b00};
            stvec_q   <= '0;
            ucen_q    <= '0;
            scen_q    <= '0;
        end else if (sw_we) begin
            case (wsel)
                SEL_MEDELEG: medeleg_q <= csr_wdata & EXC_DELEG_MASK;
                SEL_MTVEC:   mtvec_q   <= {csr_wdata[XLEN-1:2], 2'b00};
                SEL_STVEC:   stvec_q   <= {csr_wdata[XLEN-1:2], 2'b00};
                SEL_UCEN:    ucen_q    <= csr_wdata[CEN_W-1:0];
                SEL_SCEN:    scen_q    <= csr_wdata[CEN_W-1:0];
                default: ;
            endcase
        end
    end

    // Paired trap registers, one instance per level and role.
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        for (genvar i = 0; i < NPAIR; i++) begin : g_reg
            localparam csr_sel_e MYSEL = pair_sel(l, i);
            logic            trap_here;
            logic [XLEN-1:0] trap_val;
            logic [XLEN-1:0] q_r;

            assign trap_here = trap_valid && (trap_to_s == 1'(l)) && (i != 0);
            assign trap_val  = (i == 1) ? trap_epc : ((i == 2) ? trap_cause : trap_badaddr);

            // Trap load takes priority over software write.
            always_ff @(posedge clk) begin
                if (!rst_n)                           q_r <= '0;
                else if (trap_here)                   q_r <= trap_val;
                else if (sw_we && wsel == MYSEL)      q_r <= csr_wdata;
            end

            assign pair_rd[l*NPAIR + i] = q_r;
        end
    end

    // Read data mux for the read address.
    always_comb begin
        case (rsel)
            SEL_MSTATUS: csr_rdata = mstatus_v;
            SEL_SSTATUS: csr_rdata = sstatus_v;
            SEL_MIP:     csr_rdata = mip_v;
            SEL_SIP:     csr_rdata = mip_v & mideleg_v;
            SEL_MIE:     csr_rdata = mie_v;
            SEL_SIE:     csr_rdata = mie_v & mideleg_v;
            SEL_MIDELEG: csr_rdata = mideleg_v;
            SEL_MEDELEG: csr_rdata = medeleg_q;
            SEL_MTVEC:   csr_rdata = mtvec_q;
            SEL_STVEC:   csr_rdata = stvec_q;
            SEL_MSCR:    csr_rdata = pair_rd[0];
            SEL_MEPC:    csr_rdata = pair_rd[1];
            SEL_MCAUSE:  csr_rdata = pair_rd[2];
            SEL_MBAD:    csr_rdata = pair_rd[3];
            SEL_SSCR:    csr_rdata = pair_rd[4];
            SEL_SEPC:    csr_rdata = pair_rd[5];
            SEL_SCAUSE:  csr_rdata = pair_rd[6];
            SEL_SBAD:    csr_rdata = pair_rd[7];
            SEL_UCEN:    csr_rdata = XLEN'(ucen_q);
            SEL_SCEN:    csr_rdata = XLEN'(scen_q);
            SEL_HART:    csr_rdata = XLEN'(HART_ID);
            default:     csr_rdata = '0;
        endcase
    end

    // Illegal flag for the read side and for the write side.
    assign csr_illegal = !sel_hit(rsel) || (csr_we && !sel_writable(wsel));

    // R5
    tvec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == SEL_MTVEC || rsel == SEL_STVEC) |-> csr_rdata[1:0] == 2'b00);

    // R6
    cen_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == SEL_UCEN || rsel == SEL_SCEN) |-> csr_rdata[XLEN-1:CEN_W] == '0);

    // R11
    unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_raddr == 12'h7C0) |-> (csr_illegal && csr_rdata == '0));

    // R13
    trap_s_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_to_s) |=> pair_rd[5] == $past(trap_epc));

endmodule

// File: tb/test_csr_file_top.sv
// Bench: behavioural reference model of the register file, compared on
// every clock against the read port and the illegal flag.
module test_csr_file_top;

    localparam int          XL   = 32;
    localparam int unsigned HID  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 1'b0;
    logic [11:0]   csr_waddr = '0;
    logic [XL-1:0] csr_wdata = '0;
    logic [11:0]   csr_raddr = '0;
    logic [XL-1:0] csr_rdata;
    logic          csr_illegal;
    logic [XL-1:0] hw_irq_mask = '0;
    logic [XL-1:0] hw_irq_val = '0;
    logic          trap_valid = 1'b0;
    logic          trap_to_s = 1'b0;
    logic [1:0]    trap_prv = '0;
    logic [XL-1:0] trap_cause = '0;
    logic [XL-1:0] trap_epc = '0;
    logic [XL-1:0] trap_badaddr = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    csr_file_top #(.XLEN(XL), .HART_ID(HID)) i_csr_file_top (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_waddr(csr_waddr),
        .csr_wdata(csr_wdata), .csr_raddr(csr_raddr), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .hw_irq_mask(hw_irq_mask), .hw_irq_val(hw_irq_val),
        .trap_valid(trap_valid), .trap_to_s(trap_to_s), .trap_prv(trap_prv),
        .trap_cause(trap_cause), .trap_epc(trap_epc), .trap_badaddr(trap_badaddr)
    );

    always #10 clk = ~clk;

    // Reference state
    logic [31:0] st, ip, ie, dg, ed, mtv, stv, ucen, scen;
    logic [31:0] msc, mepc, mca, mbd, ssc, sepc, sca, sbd;

    function automatic bit is_impl(logic [11:0] a);
        return a inside {12'h100, 12'h104, 12'h105, 12'h140, 12'h141, 12'h142, 12'h143,
                         12'h144, 12'h300, 12'h302, 12'h303, 12'h304, 12'h305, 12'h320,
                         12'h321, 12'h340, 12'h341, 12'h342, 12'h343, 12'h344,
                         12'hF11, 12'hF12, 12'hF13, 12'hF14};
    endfunction

    function automatic bit is_wok(logic [11:0] a);
        return is_impl(a) && !(a inside {12'hF11, 12'hF12, 12'hF13, 12'hF14});
    endfunction

    function automatic logic [31:0] sdv();
        return (st[14:13] == 2'b11 || st[16:15] == 2'b11) ? 32'h8000_0000 : 32'h0;
    endfunction

    function automatic logic [31:0] mdl_read(logic [11:0] a);
        case (a)
            12'h300: return st | sdv();
            12'h100: return (st & 32'h0005_E122) | sdv();
            12'h344: return ip;
            12'h144: return ip & dg;
            12'h304: return ie;
            12'h104: return ie & dg;
            12'h303: return dg;
            12'h302: return ed;
            12'h305: return mtv;
            12'h105: return stv;
            12'h320: return ucen;
            12'h321: return scen;
            12'h340: return msc;
            12'h341: return mepc;
            12'h342: return mca;
            12'h343: return mbd;
            12'h140: return ssc;
            12'h141: return sepc;
            12'h142: return sca;
            12'h143: return sbd;
            12'hF14: return HID;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(logic [11:0] a);
        case (a)
            12'h344: return "R2";
            12'h304: return "R3";
            12'h303, 12'h302: return "R4";
            12'h305, 12'h105: return "R5";
            12'h320, 12'h321: return "R6";
            12'h300: return "R7";
            12'h100: return "R8";
            12'h144, 12'h104: return "R9";
            12'hF11, 12'hF12, 12'hF13, 12'hF14: return "R10";
            12'h340, 12'h341, 12'h342, 12'h343, 12'h140, 12'h141, 12'h142, 12'h143: return "R13";
            default: return "R11";
        endcase
    endfunction

    task automatic mdl_reset();
        st = 0; ip = 0; ie = 0; dg = 0; ed = 0; mtv = 32'h100; stv = 0; ucen = 0; scen = 0;
        msc = 0; mepc = 0; mca = 0; mbd = 0; ssc = 0; sepc = 0; sca = 0; sbd = 0;
    endtask

    task automatic mdl_write(logic [11:0] a, logic [31:0] d);
        logic [31:0] m;
        case (a)
            12'h300: st = (st & ~32'h000F_F9AA) | (d & 32'h000F_F9AA);
            12'h100: st = (st & ~32'h0005_E122) | (d & 32'h0005_E122);
            12'h344: ip = (ip & ~32'h22) | (d & 32'h22);
            12'h144: begin m = 32'h22 & dg; ip = (ip & ~m) | (d & m); end
            12'h304: ie = (ie & ~32'h12AA) | (d & 32'h12AA);
            12'h104: begin m = 32'h12AA & dg; ie = (ie & ~m) | (d & m); end
            12'h303: dg = d & 32'h1222;
            12'h302: ed = d & 32'h3FF;
            12'h305: mtv = d & ~32'h3;
            12'h105: stv = d & ~32'h3;
            12'h320: ucen = d & 32'h7;
            12'h321: scen = d & 32'h7;
            12'h340: msc = d;
            12'h341: mepc = d;
            12'h342: mca = d;
            12'h343: mbd = d;
            12'h140: ssc = d;
            12'h141: sepc = d;
            12'h142: sca = d;
            12'h143: sbd = d;
            default: ;
        endcase
    endtask

    task automatic mdl_tick();
        logic [31:0] hm;
        logic pie;
        if (trap_valid) begin
            pie = st[trap_prv];
            if (trap_to_s) begin
                sepc = trap_epc; sca = trap_cause; sbd = trap_badaddr;
                st[5] = pie; st[8] = trap_prv[0]; st[1] = 1'b0;
            end else begin
                mepc = trap_epc; mca = trap_cause; mbd = trap_badaddr;
                st[7] = pie; st[12:11] = trap_prv; st[3] = 1'b0;
            end
        end else if (csr_we && is_wok(csr_waddr)) begin
            mdl_write(csr_waddr, csr_wdata);
        end
        hm = hw_irq_mask & 32'h1AAA;
        ip = (ip & ~hm) | (hw_irq_val & hm);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: inputs already driven at the falling edge.
    task automatic cyc(string tag);
        logic ill;
        #2;
        ill = !is_impl(csr_raddr) || (csr_we && !is_wok(csr_waddr));
        chk(tag, csr_rdata, mdl_read(csr_raddr), $sformatf("rdata@%h", csr_raddr));
        chk(tag, {31'b0, csr_illegal}, {31'b0, ill}, "illegal");
        @(posedge clk);
        mdl_tick();
        @(negedge clk);
    endtask

    task automatic rw(string tag, bit we, logic [11:0] wa, logic [31:0] wd, logic [11:0] ra);
        csr_we = we; csr_waddr = wa; csr_wdata = wd; csr_raddr = ra;
        cyc(tag);
        csr_we = 0;
    endtask

    task automatic wr_rd(string tag, logic [11:0] wa, logic [31:0] wd, logic [11:0] ra);
        rw(tag, 1, wa, wd, ra);
        rw(tag, 0, 12'h0, 32'h0, ra);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] alist [26];
        alist = '{12'h100, 12'h104, 12'h105, 12'h140, 12'h141, 12'h142, 12'h143, 12'h144,
                  12'h300, 12'h302, 12'h303, 12'h304, 12'h305, 12'h320, 12'h321, 12'h340,
                  12'h341, 12'h342, 12'h343, 12'h344, 12'hF11, 12'hF12, 12'hF13, 12'hF14,
                  12'h7C0, 12'h3FF};
        mdl_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state across every address
        for (int k = 0; k < 26; k++) rw("R1", 0, 12'h0, 32'h0, alist[k]);

        wr_rd("R2", 12'h344, 32'hFFFF_FFFF, 12'h344);
        wr_rd("R3", 12'h304, 32'hFFFF_FFFF, 12'h304);
        wr_rd("R4", 12'h303, 32'hFFFF_FFFF, 12'h303);
        wr_rd("R4", 12'h302, 32'hFFFF_FFFF, 12'h302);
        wr_rd("R5", 12'h305, 32'h0000_1237, 12'h305);
        wr_rd("R5", 12'h105, 32'hABCD_EF03, 12'h105);
        wr_rd("R6", 12'h320, 32'h0000_00FF, 12'h320);
        wr_rd("R6", 12'h321, 32'hFFFF_FFFA, 12'h321);
        wr_rd("R7", 12'h300, 32'hFFFF_FFFF, 12'h300);
        wr_rd("R7", 12'h300, 32'h0000_6000, 12'h300);
        wr_rd("R7", 12'h300, 32'h0000_2000, 12'h300);
        wr_rd("R7", 12'h300, 32'h0001_8000, 12'h300);
        wr_rd("R8", 12'h300, 32'h0000_0000, 12'h100);
        wr_rd("R8", 12'h100, 32'hFFFF_FFFF, 12'h300);
        wr_rd("R8", 12'h100, 32'h0000_0000, 12'h100);
        // R9 partial delegation windows
        wr_rd("R9", 12'h303, 32'h0000_0020, 12'h144);
        wr_rd("R9", 12'h344, 32'h0000_0000, 12'h344);
        wr_rd("R9", 12'h144, 32'hFFFF_FFFF, 12'h344);
        wr_rd("R9", 12'h304, 32'h0000_0000, 12'h104);
        wr_rd("R9", 12'h104, 32'hFFFF_FFFF, 12'h304);
        for (int k = 20; k < 24; k++) rw("R10", 0, 12'h0, 32'h0, alist[k]);
        // R11 illegal reads and ignored writes
        rw("R11", 0, 12'h0, 32'h0, 12'h7C0);
        wr_rd("R11", 12'hF14, 32'h1234_5678, 12'hF14);
        wr_rd("R11", 12'h7C0, 32'h1234_5678, 12'h340);
        // R12 same-cycle write and read
        rw("R12", 1, 12'h340, 32'hDEAD_BEEF, 12'h340);
        rw("R12", 1, 12'h340, 32'h0BAD_F00D, 12'h340);
        rw("R12", 0, 12'h0, 32'h0, 12'h340);
        // R13 trap entries, including a dropped software write
        wr_rd("R13", 12'h300, 32'h0000_000A, 12'h300);
        trap_valid = 1; trap_to_s = 0; trap_prv = 2'd3;
        trap_cause = 32'h8000_0007; trap_epc = 32'h0000_4000; trap_badaddr = 32'h55;
        rw("R13", 1, 12'h340, 32'h1111_1111, 12'h341);
        trap_valid = 0;
        rw("R13", 0, 12'h0, 32'h0, 12'h300);
        rw("R13", 0, 12'h0, 32'h0, 12'h341);
        rw("R13", 0, 12'h0, 32'h0, 12'h342);
        rw("R13", 0, 12'h0, 32'h0, 12'h343);
        rw("R13", 0, 12'h0, 32'h0, 12'h340);
        trap_valid = 1; trap_to_s = 1; trap_prv = 2'd1;
        trap_cause = 32'h2; trap_epc = 32'h0000_8004; trap_badaddr = 32'hCAFE;
        rw("R13", 0, 12'h0, 32'h0, 12'h141);
        trap_valid = 0;
        rw("R13", 0, 12'h0, 32'h0, 12'h300);
        rw("R13", 0, 12'h0, 32'h0, 12'h141);
        rw("R13", 0, 12'h0, 32'h0, 12'h142);
        rw("R13", 0, 12'h0, 32'h0, 12'h143);
        // R14 hardware pending overlay beats software write
        hw_irq_mask = 32'hFFFF_FFFF; hw_irq_val = 32'h0000_0888;
        rw("R14", 1, 12'h344, 32'hFFFF_FFFF, 12'h344);
        hw_irq_mask = 32'h0000_0020; hw_irq_val = 32'h0000_0020;
        rw("R14", 0, 12'h0, 32'h0, 12'h344);
        hw_irq_mask = 0; hw_irq_val = 0;
        rw("R14", 0, 12'h0, 32'h0, 12'h344);

        // Random phase, compared every clock
        for (int n = 0; n < 600; n++) begin
            logic [11:0] ra, wa;
            ra = alist[$urandom_range(0, 25)];
            wa = alist[$urandom_range(0, 25)];
            trap_valid = ($urandom_range(0, 15) == 0);
            trap_to_s  = $urandom_range(0, 1);
            trap_prv   = trap_to_s ? 2'($urandom_range(0, 1)) : 2'($urandom_range(0, 3));
            trap_cause = $urandom; trap_epc = $urandom; trap_badaddr = $urandom;
            hw_irq_mask = ($urandom_range(0, 3) == 0) ? $urandom : 32'h0;
            hw_irq_val  = $urandom;
            rw(req_of(ra), $urandom_range(0, 1), wa, $urandom, ra);
        end
        trap_valid = 0; hw_irq_mask = 0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule